// File: doc/BRIEF.md
# Single-precision to integer and fixed-point fraction converter

This unit converts one IEEE 754 single-precision operand into a 32-bit result. The result takes one of four forms: a signed integer, an unsigned integer, a signed fraction scaled by 2^31, or an unsigned fraction scaled by 2^32. A 3-bit operation code picks the form. It also picks whether the result is truncated or rounded by a 2-bit rounding-mode input. Results are registered, so each accepted operand gives one result on the following clock, and a new operand may be presented on every cycle.

Values the selected type cannot hold saturate to the nearest bound of that type and are not wrapped. A NaN of either sign gives zero. A negative value that lands on an unsigned type gives zero. In all three cases the invalid flag is raised. A fraction conversion is handled as an integer conversion after the exponent is raised by the fraction width. Because of this, subnormal operands round exactly as the mode dictates.

Top module: `fcvt_int_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. The outputs are updated only for accepted operands.
- R2: Operation code decode. When bit 2 is set, bit 0 selects signed and bit 1 selects fraction, so codes 4, 5, 6 and 7 are unsigned integer, signed integer, unsigned fraction and signed fraction. When bit 2 is clear the result truncates toward zero: code 0 is unsigned integer, 2 is signed integer, 1 is unsigned fraction and 3 is signed fraction.
- R3: With bit 2 set, `in_rmode` encodes the rounding: 00 is nearest with ties to even, 01 is toward zero, 10 is toward plus infinity and 11 is toward minus infinity.
- R4: A rounded value outside the selected type saturates and raises invalid. Signed results saturate to 0x7FFFFFFF or 0x80000000. Unsigned results saturate to 0xFFFFFFFF.
- R5: An operand with exponent all ones and a non-zero mantissa gives 0 with invalid set, whatever its sign.
- R6: On unsigned codes, a negative operand gives 0. Invalid is raised only when the rounded magnitude is non-zero. Minus zero, or a tiny negative that rounds to zero, gives 0 without invalid.
- R7: The signed fraction result is value x 2^31 and covers [-1, 1), so -1.0 gives 0x80000000 exactly. The unsigned fraction result is value x 2^32 and covers [0, 1).
- R8: Subnormal operands follow the rounding mode. The smallest positive subnormal under an unsigned fraction code with mode 10 gives 1. Under mode 00 it gives 0.
- R9: `out_inexact` is set when discarded bits are non-zero and invalid is clear. The two flags are never both high.
- R10: An infinity saturates according to its sign and raises invalid.
- R11: During reset, `out_valid`, `out_result` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 32 | Single-precision operand |
| in_func | input | 3 | Operation code |
| in_rmode | input | 2 | Rounding mode, used when code bit 2 is set |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 32 | Converted value |
| out_invalid | output | 1 | NaN, out-of-range or negative-to-unsigned |
| out_inexact | output | 1 | Discarded bits were non-zero and no saturation |

## Verification
Rounding and saturation can act on the same operand in the same cycle. The rounding increment can push a magnitude past the bound of its type. Whether a small negative operand on an unsigned code is a clean zero or a saturating invalid also depends on the rounding decision. These cases are provoked with operands such as -0.5 under every mode on unsigned codes, with values at the fraction bounds, and with a random exponent sweep sent back to back. For each of them, a behavioural model in the bench decides the result and both flags together on every clock.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmode_e;

  typedef struct packed {
    logic use_rm;
    logic is_signed;
    logic is_frac;
  } op_t;

  // bit 2 set: bit0 = signed, bit1 = fraction; bit 2 clear: bit1 = signed, bit0 = fraction
  function automatic op_t decode_op(input logic [2:0] f);
    op_t o;
    o.use_rm    = f[2];
    o.is_signed = f[2] ? f[0] : f[1];
    o.is_frac   = f[2] ? f[1] : f[0];
    return o;
  endfunction

  function automatic logic round_inc(input rmode_e m, input logic neg,
                                     input logic lsb, input logic g, input logic st);
    case (m)
      RM_NEAR: return g & (st | lsb);
      RM_UP:   return ~neg & (g | st);
      RM_DOWN: return neg & (g | st);
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
  import fcvt_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int OUT_W = 32,
  parameter int KW    = EXP_W + 4
) (
  input  logic [EXP_W+MAN_W:0] operand,
  input  op_t                  op,
  output logic                 sign,
  output logic                 is_nan,
  output logic                 is_inf,
  output logic [MAN_W:0]       sig,
  output logic signed [KW-1:0] k
);
  localparam int IN_W = EXP_W + MAN_W + 1;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [EXP_W-1:0] e;
  logic [MAN_W-1:0] m;
  logic signed [KW-1:0] eu, scale;

  assign e      = operand[IN_W-2 -: EXP_W];
  assign m      = operand[MAN_W-1:0];
  assign sign   = operand[IN_W-1];
  assign is_nan = (&e) & (|m);
  assign is_inf = (&e) & ~(|m);
  assign sig    = {|e, m};

  always_comb begin
    eu    = (e == '0) ? KW'(1) : KW'(e);
    scale = '0;
    if (op.is_frac) scale = op.is_signed ? KW'(OUT_W - 1) : KW'(OUT_W);
    k = eu - KW'(BIAS + MAN_W) + scale;
  end
endmodule

// File: rtl/fcvt_align_round.sv
module fcvt_align_round
  import fcvt_pkg::*;
#(
  parameter int SIG_W = 24,
  parameter int OUT_W = 32,
  parameter int KW    = 12
) (
  input  logic [SIG_W-1:0]     sig,
  input  logic signed [KW-1:0] k,
  input  logic                 neg,
  input  rmode_e               rm,
  output logic [OUT_W:0]       mag,
  output logic                 huge,
  output logic                 lost
);
  localparam int EXT_W = 2 * OUT_W;
  localparam int REM_W = EXT_W - SIG_W;
  localparam int SHW   = $clog2(EXT_W);
  localparam logic signed [KW-1:0] LIM_S = KW'(OUT_W - SIG_W);
  localparam logic signed [KW-1:0] CAP_S = KW'(EXT_W - 1);

  logic signed [KW-1:0] nk;
  logic [SHW-1:0]   sh;
  logic [EXT_W-1:0] ext, shifted, tail;
  logic [SIG_W-1:0] ipart;
  logic             g, st, inc;

  always_comb begin
    nk      = -k;
    sh      = (nk >= CAP_S) ? SHW'(EXT_W - 1) : nk[SHW-1:0];
    ext     = {sig, {REM_W{1'b0}}};
    shifted = ext >> sh;
    tail    = ext & ~({EXT_W{1'b1}} << sh);
    ipart   = shifted[EXT_W-1:REM_W];
    g       = shifted[REM_W-1];
    st      = (|shifted[REM_W-2:0]) | (|tail);
    inc     = round_inc(rm, neg, ipart[0], g, st);
    huge    = 1'b0;
    lost    = 1'b0;
    mag     = '0;
    if (k > LIM_S) begin
      huge = 1'b1;
    end else if (k >= 0) begin
      mag = (OUT_W+1)'(sig) << k[SHW-1:0];
    end else begin
      mag  = (OUT_W+1)'(ipart) + (OUT_W+1)'(inc);
      lost = g | st;
    end
  end
endmodule

// File: rtl/fcvt_saturate.sv
module fcvt_saturate #(
  parameter int OUT_W = 32
) (
  input  logic [OUT_W:0]   mag,
  input  logic             huge,
  input  logic             lost,
  input  logic             neg,
  input  logic             is_nan,
  input  logic             is_signed,
  output logic [OUT_W-1:0] res,
  output logic             invalid,
  output logic             inexact
);
  localparam logic [OUT_W:0] NEG_LIM = (OUT_W+1)'(1) << (OUT_W - 1);
  localparam logic [OUT_W:0] POS_LIM = NEG_LIM - 1'b1;

  always_comb begin
    res     = '0;
    invalid = 1'b0;
    if (is_nan) begin
      invalid = 1'b1;
    end else if (is_signed) begin
      if (neg) begin
        if (huge || mag > NEG_LIM) begin
          res = {1'b1, {(OUT_W-1){1'b0}}};
          invalid = 1'b1;
        end else res = -mag[OUT_W-1:0];
      end else begin
        if (huge || mag > POS_LIM) begin
          res = {1'b0, {(OUT_W-1){1'b1}}};
          invalid = 1'b1;
        end else res = mag[OUT_W-1:0];
      end
    end else begin
      if (neg) begin
        invalid = huge || (mag != '0);
      end else if (huge || mag[OUT_W]) begin
        res = '1;
        invalid = 1'b1;
      end else res = mag[OUT_W-1:0];
    end
    inexact = lost & ~invalid;
  end

  always_comb begin
    if (!is_nan && !invalid && is_signed && !neg)
      assert_pos_sign_R4: assert (res[OUT_W-1] == 1'b0);
  end
endmodule

// File: rtl/fcvt_int_unit.sv
module fcvt_int_unit
  import fcvt_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int OUT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [EXP_W+MAN_W:0] in_operand,
  input  logic [2:0]           in_func,
  input  logic [1:0]           in_rmode,
  output logic                 out_valid,
  output logic [OUT_W-1:0]     out_result,
  output logic                 out_invalid,
  output logic                 out_inexact
);
  localparam int SIG_W = MAN_W + 1;
  localparam int KW    = EXP_W + 4;
  localparam int IN_W  = EXP_W + MAN_W + 1;

  op_t                  op;
  rmode_e               eff_rm;
  logic                 sign, is_nan, is_inf, huge, lost, inv_c, inx_c;
  logic [SIG_W-1:0]     sig;
  logic signed [KW-1:0] k;
  logic [OUT_W:0]       mag;
  logic [OUT_W-1:0]     res_c;

  assign op     = decode_op(in_func);
  assign eff_rm = op.use_rm ? rmode_e'(in_rmode) : RM_ZERO;

  fcvt_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_W(OUT_W), .KW(KW)) u_unpack (
    .operand(in_operand), .op(op), .sign(sign), .is_nan(is_nan),
    .is_inf(is_inf), .sig(sig), .k(k)
  );

  fcvt_align_round #(.SIG_W(SIG_W), .OUT_W(OUT_W), .KW(KW)) u_round (
    .sig(sig), .k(k), .neg(sign), .rm(eff_rm), .mag(mag), .huge(huge), .lost(lost)
  );

  fcvt_saturate #(.OUT_W(OUT_W)) u_sat (
    .mag(mag), .huge(huge), .lost(lost), .neg(sign), .is_nan(is_nan),
    .is_signed(op.is_signed), .res(res_c), .invalid(inv_c), .inexact(inx_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= res_c;
        out_invalid <= inv_c;
        out_inexact <= inx_c;
      end
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_nan_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (&in_operand[IN_W-2 -: EXP_W]) && (|in_operand[MAN_W-1:0]))
    |=> (out_result == '0 && out_invalid));
  assert_unsigned_neg_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op.is_signed && in_operand[IN_W-1]) |=> (out_result == '0));
  assert_inf_invalid_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (&in_operand[IN_W-2 -: EXP_W]) && !(|in_operand[MAN_W-1:0]))
    |=> out_invalid);
  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_invalid && out_inexact));
endmodule

// File: tb/fcvt_int_unit_test.sv
`timescale 1ns/1ps
module fcvt_int_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_operand = '0;
  logic [2:0]  in_func = '0;
  logic [1:0]  in_rmode = '0;
  logic        out_valid, out_invalid, out_inexact;
  logic [31:0] out_result;

  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R1";

  bit          pend_v = 1'b0;
  logic [31:0] pend_r;
  bit          pend_inv, pend_inx;
  string       pend_tag;

  always #2 clk = ~clk;

  fcvt_int_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
    .in_func(in_func), .in_rmode(in_rmode), .out_valid(out_valid),
    .out_result(out_result), .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  // Behavioural reference: bit-serial right shift, longint range compare
  function automatic void model(input logic [31:0] x, input logic [2:0] f,
                                input logic [1:0] rm, output logic [31:0] r,
                                output bit inv, output bit inx);
    bit     sgnd, frac, s, g, st, huge, up;
    int     e, kk, mode;
    longint mag, v, lo, hi;
    sgnd = f[2] ? f[0] : f[1];
    frac = f[2] ? f[1] : f[0];
    mode = f[2] ? int'(rm) : 1;
    s    = x[31];
    e    = int'(x[30:23]);
    g = 0; st = 0; huge = 0; mag = 0; inx = 0;
    if (e == 255 && x[22:0] != 0) begin
      r = 0; inv = 1; return;
    end
    mag = (e != 0) ? longint'({1'b1, x[22:0]}) : longint'(x[22:0]);
    kk  = ((e == 0) ? 1 : e) - 150 + (frac ? (sgnd ? 31 : 32) : 0);
    if (e == 255) huge = 1;
    else if (kk >= 0) begin
      if (kk > 30) huge = 1; else mag = mag << kk;
    end else begin
      for (int i = 0; i < -kk; i++) begin
        st = st | g;
        g = mag[0];
        mag = mag >> 1;
      end
    end
    case (mode)
      0: up = g && (st || mag[0]);
      2: up = !s && (g || st);
      3: up = s && (g || st);
      default: up = 0;
    endcase
    if (up) mag = mag + 1;
    lo = sgnd ? -longint'(64'd2147483648) : longint'(0);
    hi = sgnd ? longint'(64'd2147483647) : longint'(64'd4294967295);
    v  = s ? -mag : mag;
    inv = 1;
    if (huge) r = s ? lo[31:0] : hi[31:0];
    else if (v < lo) r = lo[31:0];
    else if (v > hi) r = hi[31:0];
    else begin r = v[31:0]; inv = 0; end
    inx = (g || st) && !inv;
  endfunction

  always @(negedge clk) begin
    if (rst) pend_v <= 1'b0;
    else begin
      checks++;
      if (out_valid !== pend_v) begin
        errors++;
        $display("FAIL R1 out_valid actual %b expected %b", out_valid, pend_v);
      end
      if (pend_v) begin
        checks++;
        if (out_result !== pend_r || out_invalid !== pend_inv || out_inexact !== pend_inx) begin
          errors++;
          $display("FAIL %s result/inv/inx actual %h/%b/%b expected %h/%b/%b",
                   pend_tag, out_result, out_invalid, out_inexact, pend_r, pend_inv, pend_inx);
        end
      end
      pend_v = in_valid;
      if (in_valid) begin
        model(in_operand, in_func, in_rmode, pend_r, pend_inv, pend_inx);
        pend_tag = cur_tag;
      end
    end
  end

  task automatic send(input logic [31:0] x, input logic [2:0] f,
                      input logic [1:0] rm, input string tag);
    @(posedge clk); #1;
    in_valid = 1'b1; in_operand = x; in_func = f; in_rmode = rm; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0; cur_tag = "R1";
    end
  endtask

  logic [31:0] vals [22] = '{32'h3FC00000, 32'h40200000, 32'hC0200000, 32'h3F000000,
    32'hBF000000, 32'h406CCCCD, 32'h4F800000, 32'h4F000000, 32'hCF000000, 32'h4F7FFFFF,
    32'h7F800000, 32'hFF800000, 32'h7FC00000, 32'hFFC00001, 32'h00000001, 32'h80000001,
    32'h80000000, 32'h3F400000, 32'hBF800000, 32'h3F7FFFFF, 32'h3F800000, 32'hBEFFFFFF};

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++; // R11 reset state
    if (out_valid !== 0 || out_result !== 0 || out_invalid !== 0 || out_inexact !== 0) begin
      errors++;
      $display("FAIL R11 reset outputs actual %b/%h/%b/%b expected 0/0/0/0",
               out_valid, out_result, out_invalid, out_inexact);
    end
    @(posedge clk); #1; rst = 1'b0;

    send(32'h3FC00000, 3'd4, 2'd0, "R3");  // 1.5 nearest -> 2
    send(32'h40200000, 3'd4, 2'd0, "R3");  // 2.5 tie -> 2
    send(32'h40200000, 3'd4, 2'd2, "R3");  // 2.5 up -> 3
    send(32'hC0200000, 3'd5, 2'd3, "R3");  // -2.5 down -> -3
    send(32'hC0200000, 3'd5, 2'd2, "R3");  // -2.5 up -> -2
    send(32'h3FC00000, 3'd0, 2'd2, "R2");  // truncating unsigned int
    send(32'hBFC00000, 3'd2, 2'd3, "R2");  // truncating signed int -> -1
    send(32'h3F000000, 3'd3, 2'd0, "R2");  // truncating signed fraction
    send(32'h3F000000, 3'd1, 2'd0, "R2");  // truncating unsigned fraction
    idle(2);
    send(32'hBFC00000, 3'd0, 2'd0, "R6");  // -1.5 unsigned -> 0 invalid
    send(32'hBF000000, 3'd4, 2'd0, "R6");  // -0.5 nearest -> 0 inexact
    send(32'hBF000000, 3'd4, 2'd3, "R6");  // -0.5 down -> 0 invalid
    send(32'h80000000, 3'd4, 2'd0, "R6");  // minus zero
    send(32'h4F000000, 3'd5, 2'd0, "R4");  // 2^31 signed -> sat
    send(32'hCF000000, 3'd5, 2'd0, "R4");  // -2^31 exact
    send(32'h4F800000, 3'd4, 2'd0, "R4");  // 2^32 unsigned -> sat
    send(32'h4F7FFFFF, 3'd4, 2'd0, "R4");  // largest below 2^32
    send(32'h7FC00000, 3'd5, 2'd0, "R5");
    send(32'hFFC00001, 3'd4, 2'd2, "R5");  // negative NaN
    send(32'h7F800001, 3'd7, 2'd0, "R5");
    send(32'h3F000000, 3'd7, 2'd0, "R7");
    send(32'hBF800000, 3'd7, 2'd0, "R7");  // -1.0 -> 0x80000000
    send(32'h3F800000, 3'd7, 2'd0, "R7");  // 1.0 signed frac -> sat
    send(32'h3F800000, 3'd6, 2'd0, "R7");  // 1.0 unsigned frac -> sat
    send(32'h3F7FFFFF, 3'd6, 2'd2, "R7");
    send(32'h00000001, 3'd6, 2'd2, "R8");  // tiny up -> 1
    send(32'h00000001, 3'd6, 2'd0, "R8");  // tiny nearest -> 0
    send(32'h80000001, 3'd7, 2'd3, "R8");  // tiny negative down -> -1
    send(32'h00000001, 3'd7, 2'd1, "R8");
    send(32'h406CCCCD, 3'd5, 2'd1, "R9");
    send(32'h7F800000, 3'd5, 2'd0, "R10");
    send(32'hFF800000, 3'd5, 2'd0, "R10");
    send(32'hFF800000, 3'd4, 2'd0, "R10");
    send(32'h7F800000, 3'd6, 2'd0, "R10");
    idle(3);

    foreach (vals[i])
      for (int f = 0; f < 8; f++)
        for (int m = 0; m < 4; m++)
          send(vals[i], 3'(f), 2'(m), "R3");
    idle(2);

    for (int n = 0; n < 500; n++) begin
      logic [31:0] x;
      x = $urandom;
      x[30:23] = 8'($urandom_range(90, 165));
      if (n % 7 == 0) x[30:23] = 8'($urandom_range(0, 1));
      send(x, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), "R9");
      if (n % 50 == 0) idle(1);
    end
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule